// File: doc/BRIEF.md
# Speculative Store Buffer

This block holds the address and data of stores that have executed but have not yet committed, so the data cache only ever sees committed writes. Each of its entries carries a valid flag, a speculative flag, the store's instruction tag, a sequence number that gives program age, a full word address and the store data. An executing store takes a free entry and marks it valid and speculative. A later commit, keyed by the instruction tag, clears the speculative flag. An abort, also keyed by tag, frees the entry. Committed entries leave towards the cache over a ready/valid drain port, oldest first and one per cycle.

Loads look up the buffer in the same cycle that they read the cache. The load presents its address and its own sequence number. When one or more valid entries hold the same word address and are older than the load, the youngest of them supplies the data. Otherwise the cache read data passes through unchanged. The block has eight entries by default. A store that finds no free entry is held off through a ready signal.

Top module: `spec_store_buf`

## Requirements
- R1: After synchronous active-high reset the buffer is empty: `st_ready` is 1, `dr_valid` is 0, and no load hits.
- R2: A store with `st_valid` and `st_ready` both high at a clock edge occupies one entry, which is valid and speculative from the next cycle. A speculative entry never appears on the drain port.
- R3: A commit with `cm_tag` equal to a speculative entry's tag clears that entry's speculative flag, and the entry may be offered on the drain port from the next cycle.
- R4: An abort with `ab_tag` equal to a speculative entry's tag frees that entry, and from the next cycle it neither forwards to loads nor drains. Commit and abort affect only entries that are still speculative.
- R5: Among the committed entries, the one with the oldest sequence number is offered on `dr_addr`/`dr_data` with `dr_valid`. It stays offered and unchanged while `dr_ready` is 0. It is freed at the edge where `dr_valid` and `dr_ready` are both 1, so at most one entry drains per cycle.
- R6: When a buffer entry matches a load, `ld_hit` is 1 and `ld_data` carries the buffer data, whatever `cache_rdata` holds. When nothing matches, `ld_hit` is 0 and `ld_data` equals `cache_rdata`. The lookup is combinational.
- R7: When several valid entries match, the load receives the data of the youngest entry whose sequence number is strictly older than `ld_seq`. An entry whose sequence number equals or is younger than the load's is ignored.
- R8: When all entries are valid, `st_ready` is 0, and a store presented then changes nothing.
- R9: Sequence number `a` is older than `b` when `(a - b)` modulo 2^8 has its top bit set, so that age ordering survives wraparound (250 is older than 3).
- R10: An entry matches a load only when the full 32-bit word address is equal. Bytes are never merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store execute request |
| st_tag | input | 4 | Instruction tag of the store |
| st_seq | input | 8 | Sequence number of the store |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | A free entry exists |
| cm_valid | input | 1 | Commit request |
| cm_tag | input | 4 | Tag of the committing store |
| ab_valid | input | 1 | Abort request |
| ab_tag | input | 4 | Tag of the aborted store |
| ld_valid | input | 1 | Load lookup request |
| ld_seq | input | 8 | Sequence number of the load |
| ld_addr | input | 32 | Load word address |
| cache_rdata | input | 32 | Data read from the cache for the same load |
| ld_hit | output | 1 | Load was served by the buffer |
| ld_data | output | 32 | Data returned to the load |
| dr_valid | output | 1 | A committed entry is offered to the cache |
| dr_ready | input | 1 | The cache accepts the offered write |
| dr_addr | output | 32 | Address of the offered write |
| dr_data | output | 32 | Data of the offered write |

## Verification
Most state faults show at the ports within one cycle. A lost speculative flag drains a store early, or at the wrong point in the drain order. A wrong age comparison makes a load return the data of an older or a younger store at once, on the combinational lookup. A stuck valid flag leaves `st_ready` low after the stores drain, or makes an aborted address still forward. The scoreboard compares the order and payload of every drain against the order of the commits. Because stores are executed in reverse age order, an oldest-first drain that simply follows entry index order is caught on the first drain.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int SEQ_W  = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    // payload stored per entry; flags are kept separately as vectors
    typedef struct packed {
        tag_t  tag;
        seq_t  seq;
        addr_t addr;
        data_t data;
    } ssb_slot_t;

    typedef enum logic {
        PICK_OLDEST   = 1'b0,
        PICK_YOUNGEST = 1'b1
    } age_pick_e;

    // a is older than b: modular distance a-b lies in the upper half
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

endpackage

// File: rtl/ssb_free_pick.sv
module ssb_free_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // lowest-index free slot
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ssb_age_pick.sv
module ssb_age_pick
    import ssb_pkg::*;
#(
    parameter int        DEPTH = 8,
    parameter age_pick_e MODE  = PICK_OLDEST,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            cand,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);

    seq_t best;
    logic better;

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        best   = '0;
        better = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (MODE == PICK_OLDEST) begin
                better = seq_older(seqs[i], best);
            end else begin
                better = seq_older(best, seqs[i]);
            end
            if (cand[i] && (!found || better)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = seqs[i];
            end
        end
    end

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              cm_valid,
    input  logic [TAG_W-1:0]  cm_tag,
    input  logic              ab_valid,
    input  logic [TAG_W-1:0]  ab_tag,
    input  logic              ld_valid,
    input  logic [SEQ_W-1:0]  ld_seq,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] cache_rdata,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic [ADDR_W-1:0] dr_addr,
    output logic [DATA_W-1:0] dr_data
);

    logic [DEPTH-1:0]            vld_q;
    logic [DEPTH-1:0]            spec_q;
    ssb_slot_t                   slot_q [DEPTH];
    logic [DEPTH-1:0][SEQ_W-1:0] seq_vec;
    logic [DEPTH-1:0]            drain_cand;
    logic [DEPTH-1:0]            fwd_cand;

    logic             free_found, drn_found, fwd_found;
    logic [IDX_W-1:0] free_idx, drn_idx, fwd_idx;
    logic             st_fire, dr_fire;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            seq_vec[i]    = slot_q[i].seq;
            drain_cand[i] = vld_q[i] && !spec_q[i];
            fwd_cand[i]   = ld_valid && vld_q[i]
                            && (slot_q[i].addr == ld_addr)
                            && seq_older(slot_q[i].seq, ld_seq);
        end
    end

    ssb_free_pick #(.DEPTH(DEPTH)) u_free (
        .busy  (vld_q),
        .found (free_found),
        .idx   (free_idx)
    );

    ssb_age_pick #(.DEPTH(DEPTH), .MODE(PICK_OLDEST)) u_drain_pick (
        .cand  (drain_cand),
        .seqs  (seq_vec),
        .found (drn_found),
        .idx   (drn_idx)
    );

    ssb_age_pick #(.DEPTH(DEPTH), .MODE(PICK_YOUNGEST)) u_fwd_pick (
        .cand  (fwd_cand),
        .seqs  (seq_vec),
        .found (fwd_found),
        .idx   (fwd_idx)
    );

    assign st_ready = free_found;
    assign st_fire  = st_valid && free_found;

    assign dr_valid = drn_found;
    assign dr_addr  = slot_q[drn_idx].addr;
    assign dr_data  = slot_q[drn_idx].data;
    assign dr_fire  = drn_found && dr_ready;

    assign ld_hit  = fwd_found;
    assign ld_data = fwd_found ? slot_q[fwd_idx].data : cache_rdata;

    // flag state
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            spec_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (vld_q[i] && spec_q[i]) begin
                    if (cm_valid && slot_q[i].tag == cm_tag) spec_q[i] <= 1'b0;
                    if (ab_valid && slot_q[i].tag == ab_tag) vld_q[i]  <= 1'b0;
                end
            end
            if (dr_fire) vld_q[drn_idx] <= 1'b0;
            if (st_fire) begin
                vld_q[free_idx]  <= 1'b1;
                spec_q[free_idx] <= 1'b1;
            end
        end
    end

    // payload needs no reset; it is only read under a valid flag
    always_ff @(posedge clk) begin
        if (st_fire) begin
            slot_q[free_idx] <= '{tag: st_tag, seq: st_seq, addr: st_addr, data: st_data};
        end
    end

endmodule

// File: rtl/spec_store_buf_chk.sv
module spec_store_buf_chk
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DEPTH-1:0]  vld,
    input logic [DEPTH-1:0]  spec,
    input logic              st_valid,
    input logic              st_ready,
    input logic              ab_valid,
    input logic              ld_valid,
    input logic              ld_hit,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] cache_rdata,
    input logic              dr_valid,
    input logic              dr_ready,
    input logic [ADDR_W-1:0] dr_addr,
    input logic [DATA_W-1:0] dr_data
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_ready && !dr_valid && vld == '0));

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !st_ready |-> ($countones(vld) == DEPTH));

    // R2
    spec_no_drain_chk: assert property (@(posedge clk) disable iff (rst)
        dr_valid |-> ((vld & ~spec) != '0));

    // R5
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

    // R5
    drain_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && dr_ready && !(st_valid && st_ready) && !ab_valid)
        |=> ($countones(vld) == $past($countones(vld)) - 1));

    // R6
    miss_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_hit |-> (ld_data == cache_rdata));

    // R7
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> (ld_valid && vld != '0));

endmodule

bind spec_store_buf spec_store_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vld         (vld_q),
    .spec        (spec_q),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .ab_valid    (ab_valid),
    .ld_valid    (ld_valid),
    .ld_hit      (ld_hit),
    .ld_data     (ld_data),
    .cache_rdata (cache_rdata),
    .dr_valid    (dr_valid),
    .dr_ready    (dr_ready),
    .dr_addr     (dr_addr),
    .dr_data     (dr_data)
);

// File: tb/test_spec_store_buf.sv
module test_spec_store_buf;
    import ssb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic st_valid = 0, cm_valid = 0, ab_valid = 0, ld_valid = 0, dr_ready = 0;
    tag_t st_tag = '0, cm_tag = '0, ab_tag = '0;
    seq_t st_seq = '0, ld_seq = '0;
    addr_t st_addr = '0, ld_addr = '0;
    data_t st_data = '0, cache_rdata = 32'hCAFE0000;
    logic st_ready, ld_hit, dr_valid;
    data_t ld_data, dr_data;
    addr_t dr_addr;

    spec_store_buf i_spec_store_buf (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_tag(st_tag), .st_seq(st_seq),
        .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .cm_valid(cm_valid), .cm_tag(cm_tag),
        .ab_valid(ab_valid), .ab_tag(ab_tag),
        .ld_valid(ld_valid), .ld_seq(ld_seq), .ld_addr(ld_addr),
        .cache_rdata(cache_rdata), .ld_hit(ld_hit), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready),
        .dr_addr(dr_addr), .dr_data(dr_data)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct { addr_t addr; data_t data; } drain_item_t;
    drain_item_t exp_q[$];
    addr_t m_addr [16];
    data_t m_data [16];

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_store(input tag_t t, input seq_t s, input addr_t a, input data_t d);
        @(negedge clk);
        st_valid = 1; st_tag = t; st_seq = s; st_addr = a; st_data = d;
        m_addr[t] = a; m_data[t] = d;
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic do_commit(input tag_t t);
        drain_item_t it;
        @(negedge clk);
        cm_valid = 1; cm_tag = t;
        it.addr = m_addr[t]; it.data = m_data[t];
        exp_q.push_back(it);
        @(negedge clk);
        cm_valid = 0;
    endtask

    task automatic do_abort(input tag_t t);
        @(negedge clk);
        ab_valid = 1; ab_tag = t;
        @(negedge clk);
        ab_valid = 0;
    endtask

    task automatic do_load(input string rq, input seq_t s, input addr_t a,
                           input logic exp_hit, input data_t exp_data);
        ld_valid = 1; ld_seq = s; ld_addr = a;
        #1;
        chk(rq, "ld_hit", ld_hit, exp_hit);
        chk(rq, "ld_data", ld_data, exp_data);
        ld_valid = 0;
    endtask

    // monitor: scoreboard of drains against commit order (R5, R3)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && dr_valid && dr_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R4", "unexpected drain addr", dr_addr, 64'hFFFF_FFFF_FFFF_FFFF);
                end else begin
                    drain_item_t e;
                    e = exp_q.pop_front();
                    chk("R5", "drain addr", dr_addr, e.addr);
                    chk("R5", "drain data", dr_data, e.data);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", "st_ready", st_ready, 1);
        chk("R1", "dr_valid", dr_valid, 0);
        do_load("R1", 8'd20, 32'h100, 0, 32'hCAFE0000);

        // three speculative stores
        do_store(4'd1, 8'd10, 32'h100, 32'h111);
        do_store(4'd2, 8'd12, 32'h100, 32'h222);
        do_store(4'd3, 8'd14, 32'h200, 32'h333);
        #1;
        chk("R2", "dr_valid while speculative", dr_valid, 0);
        do_load("R7", 8'd13, 32'h100, 1, 32'h222);
        do_load("R7", 8'd11, 32'h100, 1, 32'h111);
        do_load("R7", 8'd12, 32'h100, 1, 32'h111);   // equal seq ignored
        do_load("R7", 8'd10, 32'h100, 0, 32'hCAFE0000);
        do_load("R6", 8'd20, 32'h100, 1, 32'h222);
        do_load("R10", 8'd20, 32'h104, 0, 32'hCAFE0000);
        do_load("R6", 8'd20, 32'h200, 1, 32'h333);

        // R4 abort the younger match
        do_abort(4'd2);
        do_load("R4", 8'd20, 32'h100, 1, 32'h111);

        // R3 commit makes the entry drainable; R5 holds while not ready
        do_commit(4'd1);
        #1;
        chk("R3", "dr_valid after commit", dr_valid, 1);
        chk("R3", "dr_addr after commit", dr_addr, 32'h100);
        repeat (3) @(negedge clk);
        #1;
        chk("R5", "dr_valid held", dr_valid, 1);
        chk("R5", "dr_data held", dr_data, 32'h111);
        do_commit(4'd3);
        @(negedge clk);
        dr_ready = 1;
        repeat (4) @(negedge clk);
        #1;
        chk("R5", "queue drained", exp_q.size(), 0);
        chk("R5", "dr_valid empty", dr_valid, 0);
        do_load("R5", 8'd20, 32'h100, 0, 32'hCAFE0000);

        // R8 fill all entries, stores in reverse age order
        dr_ready = 0;
        for (int i = 0; i < 8; i++) begin
            do_store(tag_t'(4 + i), seq_t'(40 - 2 * i), addr_t'(32'h400 + 4 * i),
                     data_t'(32'h5000 + i));
        end
        #1;
        chk("R8", "st_ready when full", st_ready, 0);
        do_store(4'd12, 8'd50, 32'h500, 32'h9999);
        do_load("R8", 8'd60, 32'h500, 0, 32'hCAFE0000);
        do_load("R8", 8'd60, 32'h400, 1, 32'h5000);
        for (int i = 11; i >= 4; i--) begin
            do_commit(tag_t'(i));
        end
        #1;
        chk("R5", "oldest offered first", dr_addr, 32'h41C);
        @(negedge clk);
        dr_ready = 1;
        repeat (10) @(negedge clk);
        #1;
        chk("R5", "all committed drained", exp_q.size(), 0);
        chk("R8", "st_ready after drain", st_ready, 1);

        // R9 wraparound age
        do_store(4'd13, 8'd250, 32'h300, 32'hAAAA);
        do_load("R9", 8'd3, 32'h300, 1, 32'hAAAA);
        do_load("R9", 8'd240, 32'h300, 0, 32'hCAFE0000);
        do_abort(4'd13);
        do_load("R4", 8'd3, 32'h300, 0, 32'hCAFE0000);
        repeat (3) @(negedge clk);
        #1;
        chk("R4", "aborted entry not drained", dr_valid, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule